// File: doc/BRIEF.md
# Warp Divergence and Reconvergence Controller

This block holds the instruction address and the active-lane mask for one warp of parallel threads. When the warp starts, every lane runs from the same address. Each retired non-branch instruction advances the address by one. When a branch resolves, the block receives one taken bit per lane, the target address, the fall-through address and the address where the two paths rejoin.

Lanes that are already switched off take no part in the decision. If every live lane goes the same way, the warp simply jumps or falls through. If the live lanes split, the block saves two entries on a small stack. The first entry resumes the whole prior mask at the rejoin address. The second entry runs the not-taken lanes from the fall-through address. The taken lanes then run first. Each time the next address equals the rejoin address of the innermost open split, the block pops one entry and loads its address and mask. The paths are therefore serialised, and the full mask returns once both have finished.

The stack is private to one warp, so a split in one warp leaves every other warp's copy of this block untouched. If there is not room for both entries of a new split, the block refuses the split and raises an error flag.

Top module: `simt_reconv_ctrl`

## Requirements
- R1: While reset is held, the address is 0, the mask is all ones, the error flag is low and the stack is empty. A `launch` pulse loads `launch_pc`, sets every mask bit, empties the stack and clears the error flag, all visible after the next clock edge.
- R2: With `step` high and no branch or launch, the address becomes the current address plus one, unless R7 or R8 applies.
- R3: A branch whose live lanes are all taken (taken bits ANDed with the mask equal the mask) moves the address to `br_target` and leaves the mask unchanged.
- R4: A branch whose live lanes are all not taken moves the address to `br_fallthru` and leaves the mask unchanged.
- R5: Taken bits of lanes whose mask bit is 0 do not affect the agreement decision or any resulting mask.
- R6: On a split, after one edge the address is `br_target` and the mask is the live taken lanes. The stack grows by two: first {rejoin address, prior mask}, then {fall-through address, live not-taken lanes}. The mask never gains a lane.
- R7: When the next address (from a step or from an agreeing branch) equals the rejoin address of the innermost open split, the top entry is popped. The first such pop moves to the fall-through address with the not-taken lanes.
- R8: The second pop for the same split returns to the rejoin address with the full prior mask. When the stack is empty, no pop happens.
- R9: Splits nest in last-in, first-out order. Each pop lowers the stack depth by exactly one, and the depth never exceeds `DEPTH`.
- R10: A split that finds fewer than two free stack slots sets `overflow_err`. The address, the mask and the stack are left unchanged. The flag stays high until the next launch.
- R11: Priority is launch over branch over step. A branch presented together with `step` ignores the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| launch | input | 1 | Start the warp afresh at `launch_pc` |
| launch_pc | input | PC_W | Start address |
| step | input | 1 | A non-branch instruction retired; advance by one |
| br_valid | input | 1 | A branch has resolved for all lanes this cycle |
| br_taken | input | LANES | Per-lane taken bit |
| br_target | input | PC_W | Branch target address |
| br_fallthru | input | PC_W | Address after the branch |
| br_reconv | input | PC_W | Address where both paths rejoin |
| pc | output | PC_W | Current warp address |
| active_mask | output | LANES | Lanes enabled at the current address |
| overflow_err | output | 1 | Sticky flag: a split was refused for lack of stack room |

## Verification
The bench builds the block with 8 lanes, 16-bit addresses and a 4-entry stack. Masks are then short enough to pick by hand, and two nested splits fill the stack exactly. With those settings a third split hits the overflow path within a few dozen cycles. The same run walks an inner split back out through both of its pops, and then an outer split through both of its pops, so last-in, first-out ordering, the pop reached through an agreeing branch and the final full-mask restore are all exercised.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;
  // Outcome of a resolved branch over the live lanes
  typedef enum logic [1:0] {
    BK_ALL_TAKEN  = 2'd0,
    BK_NONE_TAKEN = 2'd1,
    BK_SPLIT      = 2'd2
  } br_kind_e;
endpackage

// File: rtl/simt_branch_eval.sv
module simt_branch_eval
  import simt_div_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] live_mask,
  input  logic [LANES-1:0] taken_raw,
  output br_kind_e         kind,
  output logic [LANES-1:0] taken_live,
  output logic [LANES-1:0] fall_live
);
  // Lanes that are off never vote (R5)
  function automatic br_kind_e classify(input logic [LANES-1:0] live,
                                        input logic [LANES-1:0] tk);
    if (tk == live)                 return BK_ALL_TAKEN;
    else if (tk == '0)              return BK_NONE_TAKEN;
    else                            return BK_SPLIT;
  endfunction

  always_comb begin
    taken_live = taken_raw & live_mask;
    fall_live  = ~taken_raw & live_mask;
    kind       = classify(live_mask, taken_live);
  end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack #(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 push_pair,
  input  logic [PC_W-1:0]      lo_pc,
  input  logic [LANES-1:0]     lo_mask,
  input  logic [PC_W-1:0]      lo_rpc,
  input  logic [PC_W-1:0]      hi_pc,
  input  logic [LANES-1:0]     hi_mask,
  input  logic [PC_W-1:0]      hi_rpc,
  input  logic                 pop,
  output logic [PC_W-1:0]      top_pc,
  output logic [LANES-1:0]     top_mask,
  output logic [PC_W-1:0]      top_rpc,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                 room_pair
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [PC_W-1:0]  pc_mem   [DEPTH];
  logic [LANES-1:0] mask_mem [DEPTH];
  logic [PC_W-1:0]  rpc_mem  [DEPTH];

  logic [IDX_W-1:0] wr_lo_idx, wr_hi_idx, rd_idx;

  always_comb begin
    wr_lo_idx = IDX_W'(count);
    wr_hi_idx = IDX_W'(count + CNT_W'(1));
    rd_idx    = IDX_W'(count - CNT_W'(1));
    room_pair = (int'(count) + 2) <= DEPTH;
    top_pc    = pc_mem[rd_idx];
    top_mask  = mask_mem[rd_idx];
    top_rpc   = rpc_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (push_pair && room_pair && !clear) begin
      pc_mem[wr_lo_idx]   <= lo_pc;
      mask_mem[wr_lo_idx] <= lo_mask;
      rpc_mem[wr_lo_idx]  <= lo_rpc;
      pc_mem[wr_hi_idx]   <= hi_pc;
      mask_mem[wr_hi_idx] <= hi_mask;
      rpc_mem[wr_hi_idx]  <= hi_rpc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               count <= '0;
    else if (clear)                           count <= '0;
    else if (push_pair && room_pair)          count <= count + CNT_W'(2);
    else if (pop && count != '0)              count <= count - CNT_W'(1);
  end
endmodule

// File: rtl/simt_reconv_ctrl.sv
module simt_reconv_ctrl
  import simt_div_pkg::*;
#(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [PC_W-1:0]  launch_pc,
  input  logic             step,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_taken,
  input  logic [PC_W-1:0]  br_target,
  input  logic [PC_W-1:0]  br_fallthru,
  input  logic [PC_W-1:0]  br_reconv,
  output logic [PC_W-1:0]  pc,
  output logic [LANES-1:0] active_mask,
  output logic             overflow_err
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [PC_W-1:0]  pc_q, rpc_q;
  logic [LANES-1:0] mask_q;
  logic             ovf_q;

  br_kind_e         kind;
  logic [LANES-1:0] taken_live, fall_live;
  logic [PC_W-1:0]  top_pc, top_rpc, seq_pc;
  logic [LANES-1:0] top_mask;
  logic [CNT_W-1:0] stk_count;
  logic             room_pair;

  // Named internal events, observed by the checker
  logic ev_split, ev_push, ev_ovf, ev_move, ev_pop;

  simt_branch_eval #(.LANES(LANES)) u_eval (
    .live_mask  (mask_q),
    .taken_raw  (br_taken),
    .kind       (kind),
    .taken_live (taken_live),
    .fall_live  (fall_live)
  );

  // Sequential address when the warp does not split (R2, R3, R4)
  function automatic logic [PC_W-1:0] next_linear(
      input logic            is_br,
      input br_kind_e        k,
      input logic [PC_W-1:0] cur,
      input logic [PC_W-1:0] tgt,
      input logic [PC_W-1:0] ft);
    if (!is_br)                    return cur + PC_W'(1);
    else if (k == BK_ALL_TAKEN)    return tgt;
    else                           return ft;
  endfunction

  always_comb begin
    seq_pc   = next_linear(br_valid, kind, pc_q, br_target, br_fallthru);
    ev_split = !launch && br_valid && (kind == BK_SPLIT);
    ev_push  = ev_split && room_pair;
    ev_ovf   = ev_split && !room_pair;
    ev_move  = !launch && ((br_valid && kind != BK_SPLIT) || (!br_valid && step));
    ev_pop   = ev_move && (stk_count != '0) && (seq_pc == rpc_q);
  end

  simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (launch),
    .push_pair (ev_push),
    .lo_pc     (br_reconv),
    .lo_mask   (mask_q),
    .lo_rpc    (rpc_q),
    .hi_pc     (br_fallthru),
    .hi_mask   (fall_live),
    .hi_rpc    (br_reconv),
    .pop       (ev_pop),
    .top_pc    (top_pc),
    .top_mask  (top_mask),
    .top_rpc   (top_rpc),
    .count     (stk_count),
    .room_pair (room_pair)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      mask_q <= '1;
      rpc_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (launch) begin
      pc_q   <= launch_pc;
      mask_q <= '1;
      rpc_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (ev_push) begin
      pc_q   <= br_target;
      mask_q <= taken_live;
      rpc_q  <= br_reconv;
    end else if (ev_ovf) begin
      ovf_q  <= 1'b1;
    end else if (ev_pop) begin
      pc_q   <= top_pc;
      mask_q <= top_mask;
      rpc_q  <= top_rpc;
    end else if (ev_move) begin
      pc_q   <= seq_pc;
    end
  end

  assign pc           = pc_q;
  assign active_mask  = mask_q;
  assign overflow_err = ovf_q;
endmodule

// File: rtl/simt_reconv_checker.sv
module simt_reconv_checker #(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       launch,
  input logic [PC_W-1:0]            launch_pc,
  input logic [LANES-1:0]           br_taken,
  input logic [PC_W-1:0]            pc,
  input logic [LANES-1:0]           active_mask,
  input logic                       overflow_err,
  input logic                       ev_push,
  input logic                       ev_ovf,
  input logic                       ev_pop,
  input logic [$clog2(DEPTH+1)-1:0] depth
);
  localparam int CNT_W = $clog2(DEPTH+1);

  assert_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (pc == $past(launch_pc)) && (&active_mask) && !overflow_err && (depth == '0));

  assert_split_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> active_mask == ($past(br_taken) & $past(active_mask)));

  assert_split_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> depth == $past(depth) + CNT_W'(2));

  assert_pop_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop |=> depth == $past(depth) - CNT_W'(1));

  assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(depth) <= DEPTH);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> overflow_err && $stable(pc) && $stable(active_mask) && $stable(depth));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err && !launch |=> overflow_err);

  assert_one_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_push, ev_ovf, ev_pop}));
endmodule

bind simt_reconv_ctrl simt_reconv_checker #(
  .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .launch       (launch),
  .launch_pc    (launch_pc),
  .br_taken     (br_taken),
  .pc           (pc),
  .active_mask  (active_mask),
  .overflow_err (overflow_err),
  .ev_push      (ev_push),
  .ev_ovf       (ev_ovf),
  .ev_pop       (ev_pop),
  .depth        (stk_count)
);

// File: tb/simt_reconv_ctrl_bench.sv
module simt_reconv_ctrl_bench;
  localparam int LANES = 8;
  localparam int PC_W  = 16;
  localparam int DEPTH = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             launch = 1'b0;
  logic [PC_W-1:0]  launch_pc = '0;
  logic             step = 1'b0;
  logic             br_valid = 1'b0;
  logic [LANES-1:0] br_taken = '0;
  logic [PC_W-1:0]  br_target = '0, br_fallthru = '0, br_reconv = '0;
  logic [PC_W-1:0]  pc;
  logic [LANES-1:0] active_mask;
  logic             overflow_err;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [PC_W-1:0]  q_pc   [$];
  logic [LANES-1:0] q_mask [$];
  logic             q_ovf  [$];
  string            q_tag  [$];

  always #2 clk = ~clk;

  simt_reconv_ctrl #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_simt_reconv_ctrl (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_pc(launch_pc), .step(step),
    .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
    .br_fallthru(br_fallthru), .br_reconv(br_reconv),
    .pc(pc), .active_mask(active_mask), .overflow_err(overflow_err)
  );

  task automatic compare(input string tag, input logic [PC_W-1:0] epc,
                         input logic [LANES-1:0] em, input logic eo);
    checks++;
    if (pc !== epc || active_mask !== em || overflow_err !== eo) begin
      failures++;
      $display("FAIL %s: pc=%h mask=%h ovf=%b expected pc=%h mask=%h ovf=%b",
               tag, pc, active_mask, overflow_err, epc, em, eo);
    end
  endtask

  // Monitor: one expectation per driven cycle, sampled 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (q_pc.size() != 0) begin
      compare(q_tag.pop_front(), q_pc.pop_front(), q_mask.pop_front(), q_ovf.pop_front());
    end
  end

  // Driver: applies one cycle of stimulus and queues the expected result
  task automatic drive(input logic l, input logic [PC_W-1:0] lpc, input logic s,
                       input logic bv, input logic [LANES-1:0] tk,
                       input logic [PC_W-1:0] tg, input logic [PC_W-1:0] ft,
                       input logic [PC_W-1:0] rc,
                       input logic [PC_W-1:0] epc, input logic [LANES-1:0] em,
                       input logic eo, input string tag);
    @(negedge clk);
    launch = l; launch_pc = lpc; step = s; br_valid = bv;
    br_taken = tk; br_target = tg; br_fallthru = ft; br_reconv = rc;
    q_pc.push_back(epc); q_mask.push_back(em); q_ovf.push_back(eo); q_tag.push_back(tag);
  endtask

  task automatic do_launch(input logic [PC_W-1:0] lpc, input string tag);
    drive(1'b1, lpc, 1'b0, 1'b0, '0, '0, '0, '0, lpc, '1, 1'b0, tag);
  endtask

  task automatic do_step(input logic [PC_W-1:0] epc, input logic [LANES-1:0] em,
                         input logic eo, input string tag);
    drive(1'b0, '0, 1'b1, 1'b0, '0, '0, '0, '0, epc, em, eo, tag);
  endtask

  task automatic do_br(input logic [LANES-1:0] tk, input logic [PC_W-1:0] tg,
                       input logic [PC_W-1:0] ft, input logic [PC_W-1:0] rc,
                       input logic [PC_W-1:0] epc, input logic [LANES-1:0] em,
                       input logic eo, input string tag);
    drive(1'b0, '0, 1'b0, 1'b1, tk, tg, ft, rc, epc, em, eo, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset", 16'h0000, 8'hFF, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset", 16'h0000, 8'hFF, 1'b0);

    do_launch(16'h0100, "R1 launch");
    do_step(16'h0101, 8'hFF, 1'b0, "R2 step");
    do_br(8'hFF, 16'h0200, 16'h0102, 16'h0300, 16'h0200, 8'hFF, 1'b0, "R3 all taken");
    do_br(8'h00, 16'h0400, 16'h0201, 16'h0300, 16'h0201, 8'hFF, 1'b0, "R4 none taken");
    do_br(8'h0F, 16'h0210, 16'h0202, 16'h0220, 16'h0210, 8'h0F, 1'b0, "R6 split");
    do_br(8'hCF, 16'h0212, 16'h0211, 16'h0300, 16'h0212, 8'h0F, 1'b0, "R5 inactive bits set");
    do_br(8'h30, 16'h0500, 16'h0213, 16'h0300, 16'h0213, 8'h0F, 1'b0, "R5 only inactive taken");
    do_br(8'hFF, 16'h021F, 16'h0214, 16'h0000, 16'h021F, 8'h0F, 1'b0, "R3 inside path");
    do_step(16'h0202, 8'hF0, 1'b0, "R7 first pop to fall path");
    do_step(16'h0203, 8'hF0, 1'b0, "R2 step in fall path");
    do_br(8'hF0, 16'h021F, 16'h0204, 16'h0000, 16'h021F, 8'hF0, 1'b0, "R3 fall path jump");
    do_step(16'h0220, 8'hFF, 1'b0, "R8 rejoin full mask");
    do_step(16'h0221, 8'hFF, 1'b0, "R8 empty stack no pop");

    do_br(8'h3C, 16'h0240, 16'h0230, 16'h0260, 16'h0240, 8'h3C, 1'b0, "R6 outer split");
    do_br(8'h0C, 16'h0244, 16'h0241, 16'h0250, 16'h0244, 8'h0C, 1'b0, "R9 inner split");
    do_br(8'h04, 16'h0248, 16'h0245, 16'h0249, 16'h0244, 8'h0C, 1'b1, "R10 overflow refused");
    do_step(16'h0245, 8'h0C, 1'b1, "R10 flag sticky");
    do_br(8'h0C, 16'h0250, 16'h0246, 16'h0000, 16'h0241, 8'h30, 1'b1, "R9 inner pop via branch");
    do_br(8'h30, 16'h024F, 16'h0242, 16'h0000, 16'h024F, 8'h30, 1'b1, "R3 inner else jump");
    do_step(16'h0250, 8'h3C, 1'b1, "R9 inner rejoin");
    do_br(8'h3C, 16'h0260, 16'h0251, 16'h0000, 16'h0230, 8'hC3, 1'b1, "R9 outer else");
    do_br(8'hC3, 16'h025F, 16'h0231, 16'h0000, 16'h025F, 8'hC3, 1'b1, "R3 outer else jump");
    do_step(16'h0260, 8'hFF, 1'b1, "R9 outer rejoin");

    drive(1'b0, '0, 1'b1, 1'b1, 8'hFF, 16'h0300, 16'h0261, 16'h0000,
          16'h0300, 8'hFF, 1'b1, "R11 branch beats step");
    drive(1'b1, 16'h0010, 1'b1, 1'b1, 8'h0F, 16'h0700, 16'h0301, 16'h0800,
          16'h0010, 8'hFF, 1'b0, "R11 launch beats branch, R1 clears flag");
    drive(1'b0, '0, 1'b0, 1'b0, '0, '0, '0, '0, 16'h0010, 8'hFF, 1'b0, "R2 idle holds");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule